// File: doc/BRIEF.md
# Vehicle Bus Transmit Opcode Controller

This block sits between a host and the byte transmitter of a pulse-width-modulated vehicle network interface. The host writes 3-bit transmit opcodes. The block keeps at most one of them waiting and decides when each may start. It then hands the byte transmitter a start pulse, the opcode, and a flag telling it to append a CRC byte after the data byte. Symbol timing, CRC arithmetic and line coding live elsewhere; this block sees them only as status inputs and a "byte finished" pulse.

The type-3 in-frame response with CRC needs the most care. It can open an in-frame response right after a received data field, or it can close a running type-3 string. When it opens a response, it is checked against several receiver and transmitter conditions in a fixed order. The first condition that fails decides the outcome: a CRC error flag, an abort flag, an inverted-CRC command, or a refusal with no flag. A byte that ends a chained opcode with no continuation waiting raises an underflow flag and an inverted-CRC command. The host can cancel a waiting opcode at any time. All three error flags stay set until the host clears them.

Top module: `vbus_txop_ctl`

## Requirements
- R1: Opcode codes are 0 CANCEL, 1 MSG, 2 MSG_CRC, 3 IFR1, 4 IFR2, 5 IFR3, 6 IFR3_CRC and 7 reserved. Code 7 is ignored. Only one opcode can wait at a time. A write that arrives while an opcode is waiting is ignored, except CANCEL and the override in R11.
- R2: The ready flag `trdy` is 1 after reset. It goes to 0 in the cycle after a write is accepted. It returns to 1 when the waiting opcode starts or is cancelled.
- R3: A waiting opcode starts only when no byte is active. MSG and MSG_CRC also wait for `line_idle`. A start produces a one-cycle `tx_start` with `tx_code` equal to the opcode. `tx_crc` is 1 for codes 2 and 6, and 0 for the other codes.
- R4: When IFR3_CRC opens a response and `rx_crc_ok` is 0, the opcode is refused and error bit 0 (CRC error) is set. This check comes before all the others.
- R5: Next, if `len_chk_en` is 1 and `rx_len_ok` is 0, the opcode is refused and error bit 1 (abort) is set.
- R6: Next, if `rx_eod_ok` is 0, the opcode is refused and no flag is set.
- R7: Next, if `no_len_limit` is 0 and `rx_cnt_gt10` is 1, the opcode is refused, error bit 1 is set, and `tx_inv_crc` pulses in the cycle after the write.
- R8: Last, if a byte of code 1 or 2 is active, or a byte of code 3, 4 or 6 is active, or `rx_in_ifr` is 1, the opcode is refused and error bit 1 is set. An active IFR1, IFR2 or IFR3_CRC byte never leads to an underflow.
- R9: Codes 1 (MSG) and 5 (IFR3) are the chained opcodes. When a chained byte finishes (`tx_done`) and a continuation is waiting, the continuation starts on that same edge. For MSG a continuation is code 1 or 2; for IFR3 it is code 5 or 6. If no continuation is waiting, error bit 2 (underflow) is set and `tx_inv_crc` pulses.
- R10: When an IFR3 byte is active, IFR3_CRC is checked only against the byte-count condition of R7. If it is accepted, it starts on the edge where the IFR3 byte finishes.
- R11: An IFR3_CRC that passes its checks replaces a waiting MSG or MSG_CRC.
- R12: CANCEL removes any waiting opcode and sets `trdy`. If a chained byte is active, cancelling its continuation leads to the underflow of R9.
- R13: Error flags stay set until the host writes a 1 to the matching `err_clr` bit. The bits are: bit 0 CRC error, bit 1 abort, bit 2 underflow. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_wr | input | 1 | Opcode write strobe |
| op_code | input | 3 | Opcode value |
| err_clr | input | 3 | Write-one-to-clear for the error flags |
| rx_crc_ok | input | 1 | Received frame CRC is valid |
| len_chk_en | input | 1 | Message length checking enabled |
| rx_len_ok | input | 1 | Received message length is valid |
| rx_eod_ok | input | 1 | Minimum end-of-data symbol received |
| no_len_limit | input | 1 | Frame byte-count limit disabled |
| rx_cnt_gt10 | input | 1 | Received byte count of the frame exceeds 10 |
| rx_in_ifr | input | 1 | Receiver is inside a response portion |
| line_idle | input | 1 | Bus is free for a new message |
| tx_done | input | 1 | Active byte has finished |
| tx_start | output | 1 | Start pulse to the byte transmitter |
| tx_code | output | 3 | Opcode of the byte being started |
| tx_crc | output | 1 | Append CRC after this byte |
| tx_inv_crc | output | 1 | Send an inverted CRC (one-cycle pulse) |
| trdy | output | 1 | Ready for a new opcode |
| err_flags | output | 3 | Sticky error flags |

## Verification
Some properties are checked on every cycle:
- `trdy` never falls without a write.
- A waiting opcode never changes unless a write arrives.
- Every start comes from an opcode that was waiting.
- An underflow is always followed by an inverted-CRC pulse.
- Each error flag holds until it is cleared.

Other behaviour can only be shown by the bench scenarios: the order in which the IFR3_CRC conditions take priority, the override of a waiting MSG, chaining on the edge a byte finishes, and the difference between an abort that later underflows and one that does not.

// File: rtl/vbt_pkg.sv
package vbt_pkg;
  localparam int OP_W  = 3;
  localparam int ERR_W = 3;
  localparam int E_CRC = 0;
  localparam int E_ABT = 1;
  localparam int E_UDF = 2;

  typedef enum logic [OP_W-1:0] {
    OP_CANCEL  = 3'd0,
    OP_MSG     = 3'd1,
    OP_MSG_CRC = 3'd2,
    OP_IFR1    = 3'd3,
    OP_IFR2    = 3'd4,
    OP_IFR3    = 3'd5,
    OP_IFR3CRC = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  function automatic logic is_msg(op_e o);
    return (o == OP_MSG) || (o == OP_MSG_CRC);
  endfunction

  function automatic logic adds_crc(op_e o);
    return (o == OP_MSG_CRC) || (o == OP_IFR3CRC);
  endfunction

  function automatic logic is_chained(op_e o);
    return (o == OP_MSG) || (o == OP_IFR3);
  endfunction

  function automatic logic continues(op_e act, op_e nxt);
    return ((act == OP_MSG) && is_msg(nxt)) ||
           ((act == OP_IFR3) && ((nxt == OP_IFR3) || (nxt == OP_IFR3CRC)));
  endfunction
endpackage

// File: rtl/vbt_ifr3_qual.sv
module vbt_ifr3_qual (
  input  logic chain_i,
  input  logic act_vld_i,
  input  logic act_msg_i,
  input  logic crc_ok_i,
  input  logic len_en_i,
  input  logic len_ok_i,
  input  logic eod_ok_i,
  input  logic no_lim_i,
  input  logic cnt_gt_i,
  input  logic in_ifr_i,
  output logic ok_o,
  output logic set_crce_o,
  output logic set_abt_o,
  output logic send_inv_o
);
  logic cnt_bad;
  assign cnt_bad = !no_lim_i && cnt_gt_i;

  always_comb begin
    ok_o       = 1'b0;
    set_crce_o = 1'b0;
    set_abt_o  = 1'b0;
    send_inv_o = 1'b0;
    if (chain_i) begin
      if (cnt_bad) begin
        set_abt_o  = 1'b1;
        send_inv_o = 1'b1;
      end else begin
        ok_o = 1'b1;
      end
    end else if (!crc_ok_i) begin
      set_crce_o = 1'b1;
    end else if (len_en_i && !len_ok_i) begin
      set_abt_o = 1'b1;
    end else if (!eod_ok_i) begin
      ok_o = 1'b0;
    end else if (cnt_bad) begin
      set_abt_o  = 1'b1;
      send_inv_o = 1'b1;
    end else if (act_msg_i || act_vld_i || in_ifr_i) begin
      set_abt_o = 1'b1;
    end else begin
      ok_o = 1'b1;
    end
  end
endmodule

// File: rtl/vbt_txq.sv
module vbt_txq
  import vbt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  op_e             op_i,
  input  logic            q_ok_i,
  input  logic            q_inv_i,
  input  logic            line_idle_i,
  input  logic            tx_done_i,
  output logic            act_vld_o,
  output op_e             act_op_o,
  output logic            udf_o,
  output logic            trdy_o,
  output logic            tx_start_o,
  output logic [OP_W-1:0] tx_code_o,
  output logic            tx_crc_o,
  output logic            tx_inv_o
);
  logic pend_vld_q, pend_vld_n, act_vld_q, act_vld_n, trdy_q, trdy_n;
  op_e  pend_op_q, pend_op_n, act_op_q, act_op_n;
  logic start_q, crc_q, inv_q, inv_n;
  logic [OP_W-1:0] code_q;
  logic done_ev, cont, launch, accept, cancel;

  assign done_ev = act_vld_q && tx_done_i;
  assign cont    = pend_vld_q && continues(act_op_q, pend_op_q);
  assign launch  = (pend_vld_q && !act_vld_q && (!is_msg(pend_op_q) || line_idle_i))
                 || (done_ev && cont);
  assign udf_o   = done_ev && is_chained(act_op_q) && !cont;
  assign cancel  = wr_i && (op_i == OP_CANCEL);

  always_comb begin
    accept = 1'b0;
    if (wr_i) begin
      if (op_i == OP_IFR3CRC)
        accept = q_ok_i && (!pend_vld_q || is_msg(pend_op_q));
      else if ((op_i != OP_CANCEL) && (op_i != OP_RSVD))
        accept = !pend_vld_q;
    end
  end

  always_comb begin
    pend_vld_n = pend_vld_q && !launch;
    pend_op_n  = pend_op_q;
    trdy_n     = trdy_q || launch;
    if (cancel) begin
      pend_vld_n = 1'b0;
      trdy_n     = 1'b1;
    end else if (accept) begin
      pend_vld_n = 1'b1;
      pend_op_n  = op_i;
      trdy_n     = 1'b0;
    end
    act_vld_n = launch ? 1'b1 : (act_vld_q && !done_ev);
    act_op_n  = launch ? pend_op_q : act_op_q;
    inv_n     = udf_o || (wr_i && (op_i == OP_IFR3CRC) && q_inv_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_op_q  <= OP_CANCEL;
      act_vld_q  <= 1'b0;
      act_op_q   <= OP_CANCEL;
      trdy_q     <= 1'b1;
      start_q    <= 1'b0;
      inv_q      <= 1'b0;
      code_q     <= '0;
      crc_q      <= 1'b0;
    end else begin
      pend_vld_q <= pend_vld_n;
      pend_op_q  <= pend_op_n;
      act_vld_q  <= act_vld_n;
      act_op_q   <= act_op_n;
      trdy_q     <= trdy_n;
      start_q    <= launch;
      inv_q      <= inv_n;
      if (launch) begin
        code_q <= pend_op_q;
        crc_q  <= adds_crc(pend_op_q);
      end
    end
  end

  assign act_vld_o  = act_vld_q;
  assign act_op_o   = act_op_q;
  assign trdy_o     = trdy_q;
  assign tx_start_o = start_q;
  assign tx_code_o  = code_q;
  assign tx_crc_o   = crc_q;
  assign tx_inv_o   = inv_q;

  // R2
  trdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(trdy_q) |-> $past(wr_i));
  // R3
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    start_q |-> $past(pend_vld_q));
  // R1
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_vld_q && $past(pend_vld_q) && !$past(wr_i)) |-> $stable(pend_op_q));
  // R9
  udf_inv_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    udf_o |=> inv_q);
endmodule

// File: rtl/vbt_errf.sv
module vbt_errf #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q, flags_n;
  logic         upd;

  assign upd = (|set_i) || (|clr_i);

  always_comb flags_n = (flags_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  flags_q <= '0;
    else if (upd) flags_q <= flags_n;
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R13
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      ($past(flags_q[i]) && !$past(clr_i[i])) |-> flags_q[i]);
    // R13
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      $past(set_i[i]) |-> flags_q[i]);
  end
endmodule

// File: rtl/vbus_txop_ctl.sv
module vbus_txop_ctl
  import vbt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_wr,
  input  logic [OP_W-1:0]  op_code,
  input  logic [ERR_W-1:0] err_clr,
  input  logic             rx_crc_ok,
  input  logic             len_chk_en,
  input  logic             rx_len_ok,
  input  logic             rx_eod_ok,
  input  logic             no_len_limit,
  input  logic             rx_cnt_gt10,
  input  logic             rx_in_ifr,
  input  logic             line_idle,
  input  logic             tx_done,
  output logic             tx_start,
  output logic [OP_W-1:0]  tx_code,
  output logic             tx_crc,
  output logic             tx_inv_crc,
  output logic             trdy,
  output logic [ERR_W-1:0] err_flags
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  op_e  op;
  op_e  act_op;
  logic act_vld, udf, q_ok, q_crce, q_abt, q_inv, is_i3c;
  logic [ERR_W-1:0] err_set;

  assign op     = op_e'(op_code);
  assign is_i3c = op_wr && (op == OP_IFR3CRC);

  vbt_ifr3_qual u_qual (
    .chain_i    (act_vld && (act_op == OP_IFR3)),
    .act_vld_i  (act_vld),
    .act_msg_i  (act_vld && is_msg(act_op)),
    .crc_ok_i   (rx_crc_ok),
    .len_en_i   (len_chk_en),
    .len_ok_i   (rx_len_ok),
    .eod_ok_i   (rx_eod_ok),
    .no_lim_i   (no_len_limit),
    .cnt_gt_i   (rx_cnt_gt10),
    .in_ifr_i   (rx_in_ifr),
    .ok_o       (q_ok),
    .set_crce_o (q_crce),
    .set_abt_o  (q_abt),
    .send_inv_o (q_inv)
  );

  vbt_txq u_txq (
    .clk         (clk),
    .rst_ni      (rst_int_n),
    .wr_i        (op_wr),
    .op_i        (op),
    .q_ok_i      (q_ok),
    .q_inv_i     (q_inv),
    .line_idle_i (line_idle),
    .tx_done_i   (tx_done),
    .act_vld_o   (act_vld),
    .act_op_o    (act_op),
    .udf_o       (udf),
    .trdy_o      (trdy),
    .tx_start_o  (tx_start),
    .tx_code_o   (tx_code),
    .tx_crc_o    (tx_crc),
    .tx_inv_o    (tx_inv_crc)
  );

  always_comb begin
    err_set        = '0;
    err_set[E_CRC] = is_i3c && q_crce;
    err_set[E_ABT] = is_i3c && q_abt;
    err_set[E_UDF] = udf;
  end

  vbt_errf #(.W(ERR_W)) u_errf (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .set_i   (err_set),
    .clr_i   (err_clr),
    .flags_o (err_flags)
  );

  // R4
  crce_src_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(err_flags[E_CRC]) |-> $past(op_wr && (op_code == 3'd6)));
  // R7
  inv_src_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_inv_crc |-> $past(op_wr || tx_done));
endmodule

// File: tb/vbus_txop_ctl_tb.sv
module vbus_txop_ctl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic op_wr;
  logic [2:0] op_code, err_clr;
  logic rx_crc_ok, len_chk_en, rx_len_ok, rx_eod_ok, no_len_limit;
  logic rx_cnt_gt10, rx_in_ifr, line_idle, tx_done;
  logic tx_start, tx_crc, tx_inv_crc, trdy;
  logic [2:0] tx_code, err_flags;
  int n_run = 0, n_fail = 0;
  bit done_run = 0;

  always #10 clk = ~clk;

  vbus_txop_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_code(op_code), .err_clr(err_clr),
    .rx_crc_ok(rx_crc_ok), .len_chk_en(len_chk_en), .rx_len_ok(rx_len_ok),
    .rx_eod_ok(rx_eod_ok), .no_len_limit(no_len_limit), .rx_cnt_gt10(rx_cnt_gt10),
    .rx_in_ifr(rx_in_ifr), .line_idle(line_idle), .tx_done(tx_done),
    .tx_start(tx_start), .tx_code(tx_code), .tx_crc(tx_crc),
    .tx_inv_crc(tx_inv_crc), .trdy(trdy), .err_flags(err_flags)
  );

  // {crc_ok,len_en,len_ok,eod,no_lim,cnt_gt,in_ifr, exp_crce,exp_abt,exp_inv,exp_start}
  localparam logic [10:0] VEC [10] = '{
    11'b1111000_0001,  // all good: starts
    11'b0111000_1000,  // R4 CRC bad
    11'b0101000_1000,  // R4 CRC bad beats length bad
    11'b1101000_0100,  // R5 length bad
    11'b1001000_0001,  // R5 length check disabled
    11'b1110000_0000,  // R6 no end-of-data, silent
    11'b1111010_0110,  // R7 byte count over
    11'b1111110_0001,  // R7 limit disabled
    11'b1111001_0100,  // R8 receiving response
    11'b1110010_0000   // R6 before R7
  };

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; op_wr = 0; op_code = 0; err_clr = 0; tx_done = 0;
    rx_crc_ok = 1; len_chk_en = 1; rx_len_ok = 1; rx_eod_ok = 1;
    no_len_limit = 0; rx_cnt_gt10 = 0; rx_in_ifr = 0; line_idle = 1;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic wr_op(input logic [2:0] c);
    op_wr = 1'b1; op_code = c;
    step();
    op_wr = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done = 1'b1;
    step();
    tx_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    // table of IFR3_CRC qualification cases
    for (int i = 0; i < 10; i++) begin
      do_reset();
      {rx_crc_ok, len_chk_en, rx_len_ok, rx_eod_ok, no_len_limit, rx_cnt_gt10, rx_in_ifr} = VEC[i][10:4];
      wr_op(3'd6);
      chk("R4 crc flag", err_flags[0], VEC[i][3]);
      chk("R5/R7/R8 abort flag", err_flags[1], VEC[i][2]);
      chk("R7 inverted crc", tx_inv_crc, VEC[i][1]);
      step();
      chk("R6 start", tx_start, VEC[i][0]);
      if (VEC[i][0]) begin
        chk("R3 code", tx_code, 6);
        chk("R3 crc append", tx_crc, 1);
      end
    end

    // reset state
    do_reset();
    chk("R2 reset trdy", trdy, 1);
    chk("R13 reset flags", err_flags, 0);
    chk("R3 reset start", tx_start, 0);

    // MSG waits for line idle
    do_reset(); line_idle = 0;
    wr_op(3'd1);
    chk("R2 trdy clear", trdy, 0);
    step();
    chk("R3 no start busy line", tx_start, 0);
    line_idle = 1;
    step();
    chk("R3 start", tx_start, 1);
    chk("R3 code", tx_code, 1);
    chk("R3 no crc", tx_crc, 0);
    chk("R2 trdy set", trdy, 1);

    // write refused while pending
    do_reset(); line_idle = 0;
    wr_op(3'd1); wr_op(3'd3);
    line_idle = 1; step();
    chk("R1 refused keeps MSG", tx_code, 1);

    // reserved code
    do_reset();
    wr_op(3'd7);
    chk("R1 reserved trdy", trdy, 1);
    step();
    chk("R1 reserved no start", tx_start, 0);

    // override of waiting MSG
    do_reset(); line_idle = 0;
    wr_op(3'd1); wr_op(3'd6);
    chk("R11 no flags", err_flags, 0);
    step();
    chk("R11 start", tx_start, 1);
    chk("R11 code", tx_code, 6);

    // cancel while idle
    do_reset(); line_idle = 0;
    wr_op(3'd1); wr_op(3'd0);
    chk("R12 trdy", trdy, 1);
    line_idle = 1; step();
    chk("R12 nothing starts", tx_start, 0);

    // MSG active: abort then underflow
    do_reset();
    wr_op(3'd1); step();
    wr_op(3'd6);
    chk("R8 abort msg active", err_flags, 3'b010);
    pulse_done();
    chk("R9 underflow", err_flags[2], 1);
    chk("R9 inverted crc", tx_inv_crc, 1);

    // IFR1 active: abort, no underflow
    do_reset();
    wr_op(3'd3); step();
    wr_op(3'd6);
    chk("R8 abort ifr active", err_flags, 3'b010);
    pulse_done();
    chk("R8 no underflow", err_flags[2], 0);
    chk("R8 no inverted crc", tx_inv_crc, 0);

    // IFR3 chain ignores first-byte checks
    do_reset();
    wr_op(3'd5); step();
    rx_crc_ok = 0; rx_eod_ok = 0;
    wr_op(3'd6);
    chk("R10 accepted", err_flags, 0);
    step();
    chk("R10 waits", tx_start, 0);
    pulse_done();
    chk("R10 start at done", tx_start, 1);
    chk("R10 code", tx_code, 6);
    chk("R10 no underflow", err_flags[2], 0);

    // IFR3 chain with byte count over
    do_reset();
    wr_op(3'd5); step();
    rx_cnt_gt10 = 1;
    wr_op(3'd6);
    chk("R7 chain abort", err_flags[1], 1);
    chk("R7 chain inverted", tx_inv_crc, 1);
    pulse_done();
    chk("R9 ifr3 underflow", err_flags[2], 1);

    // MSG continuation
    do_reset();
    wr_op(3'd1); step();
    wr_op(3'd2);
    pulse_done();
    chk("R9 continuation start", tx_start, 1);
    chk("R9 continuation crc", tx_crc, 1);
    chk("R9 no underflow", err_flags[2], 0);

    // cancel while transmitting
    do_reset();
    wr_op(3'd1); step();
    wr_op(3'd1); wr_op(3'd0);
    chk("R12 trdy busy", trdy, 1);
    pulse_done();
    chk("R12 no start", tx_start, 0);
    chk("R12 underflow", err_flags[2], 1);

    // write-one-to-clear
    err_clr = 3'b001; step(); err_clr = 0;
    chk("R13 other bit kept", err_flags[2], 1);
    err_clr = 3'b100; step(); err_clr = 0;
    chk("R13 cleared", err_flags, 0);

    finish_run();
  end
endmodule